// File: doc/BRIEF.md
# Counted Full-Duplex SPI Master

This block is an SPI controller that is fed and drained by valid/ready word streams. Each transfer starts when the block accepts a bit-count word from the transmit stream. It then exchanges exactly that many bits on the serial pins, in both directions at once. Outgoing bits are taken from the transmit words that follow the count. Incoming bits are packed into words on the receive stream. The serial clock runs at one quarter of the system clock and idles low. The chip select is driven low for the duration of a transfer.

A static phase input chooses which serial clock edge launches data and which edge captures it. If the transmit stream has no word ready when one is needed, the block waits without losing bits, with the chip select held low and the serial clock at its idle level. It does the same when the receive stream cannot take a finished word.

Top module: `spi_stream_master`

## Requirements
- R1: The first word accepted while idle is taken as a bit count N. A count of 0 takes no data words, leaves cs_n high and returns to idle.
- R2: Each bit lasts exactly 4 system clocks: 2 with sclk at one level and 2 at the other. sclk is 0 whenever cs_n is high or the block is stalled. A transfer without stalls keeps cs_n low for 4N cycles, plus 1 when N is not a multiple of 32.
- R3: cs_n falls once per transfer with N>0 and stays low until the last bit and any final receive word are done. Before it falls, it has been high for at least 2 cycles.
- R4: With cpha=0, sclk is low for the first 2 cycles of each bit and high for the last 2. mosi changes only at the start of a bit, which is the falling edge of cs_n or of sclk. miso is captured at the end of the first system cycle after sclk rises.
- R5: With cpha=1, sclk is high for the first 2 cycles of each bit and low for the last 2. mosi changes only at the start of a bit, which is the rising edge of sclk. miso is captured at the end of the first system cycle after sclk falls.
- R6: Bits are sent MSB-first. The block takes ceil(N/32) transmit words after the count. Bits of the last word beyond N are not sent.
- R7: Received bits are packed MSB-first into 32-bit words. A final partial word of r bits holds them in bits 31 down to 32-r, with zeros below. Exactly ceil(N/32) receive words are produced.
- R8: When a transmit word is needed and tx_valid is low, the block waits with cs_n low and sclk idle. It then resumes without losing or repeating bits.
- R9: When a receive word is complete and the output word has not been accepted, the block waits before the bit that would complete the next word. No received data is dropped.
- R10: busy is high from the cycle after the count is accepted until cs_n is high again at the end of the transfer. It is high whenever cs_n is low.
- R11: Once rx_valid is high, it stays high with rx_data unchanged until rx_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpha | input | 1 | Clock phase select, held constant while busy |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 32 | Transmit word: bit count first, then data words |
| tx_ready | output | 1 | Transmit word accepted this cycle when tx_valid is high |
| rx_valid | output | 1 | Receive word available |
| rx_data | output | 32 | Receive word, MSB-first |
| rx_ready | input | 1 | Consumer takes the receive word |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume two things. First, cpha does not change while busy is high. Second, the receive consumer follows the stream rule, so a word offered with rx_ready low is still counted as pending on the next cycle. The bench changes cpha only between transfers, while the block is idle.

The bench's slave model returns mosi on miso only in the cycle the requirements name as the capture point, and returns the complement in every other cycle. A wrong capture point therefore shows up as corrupted receive data. In runs with stalls, the bench gates tx_valid and rx_ready with fixed cycle patterns. It then checks the data and the edge counts, not the cycle-exact timing.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ACT,
        ST_WAIT,
        ST_FLUSH
    } seq_state_e;

endpackage

// File: rtl/spi_tx_unpack.sv
module spi_tx_unpack #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         msb,
    output logic         last,
    output logic         empty
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } tx_reg_t;

    tx_reg_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.sh  = word;
            d.cnt = CW'(W);
        end else if (shift) begin
            d.sh  = q.sh << 1;
            d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign msb   = q.sh[W-1];
    assign last  = (q.cnt == CW'(1));
    assign empty = (q.cnt == '0);

    // R6: a bit is only shifted out of a register that still holds one
    p_shift_has_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !empty);

endmodule

// File: rtl/spi_rx_pack.sv
module spi_rx_pack #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         bit_in,
    input  logic         flush,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         room,
    output logic         out_free,
    output logic         partial
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic [W-1:0]  data;
        logic          valid;
    } rx_reg_t;

    rx_reg_t d, q;
    logic [CW-1:0] pad;
    logic          push;

    assign pad  = CW'(W) - q.cnt;
    assign push = flush || (sample && q.cnt == CW'(W - 1));

    always_comb begin
        d = q;
        if (q.valid && out_ready) d.valid = 1'b0;
        if (sample) begin
            if (q.cnt == CW'(W - 1)) begin
                d.data  = {q.sh[W-2:0], bit_in};
                d.valid = 1'b1;
                d.sh    = '0;
                d.cnt   = '0;
            end else begin
                d.sh  = {q.sh[W-2:0], bit_in};
                d.cnt = q.cnt + CW'(1);
            end
        end else if (flush) begin
            d.data  = q.sh << pad;
            d.valid = 1'b1;
            d.sh    = '0;
            d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.valid;
    assign out_data  = q.data;
    assign out_free  = !q.valid || out_ready;
    assign room      = (q.cnt != CW'(W - 1)) || out_free;
    assign partial   = (q.cnt != '0);

    // R9: a finished word never overwrites one still waiting
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!q.valid || out_ready));

    // R11: an offered word is held until taken
    p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !out_ready) |=> (q.valid && $stable(q.data)));

endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master #(
    parameter int W     = 32,
    parameter int CNT_W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpha,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    output logic         tx_ready,
    output logic         rx_valid,
    output logic [W-1:0] rx_data,
    input  logic         rx_ready,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso,
    output logic         cs_n,
    output logic         busy
);
    import spi_stream_pkg::*;

    typedef struct packed {
        seq_state_e       state;
        logic [1:0]       ph;
        logic [CNT_W-1:0] left;
    } seq_reg_t;

    seq_reg_t d, q;

    logic tx_load, tx_shift, tx_last, tx_empty;
    logic rx_sample, rx_flush, rx_room, rx_free, rx_partial;

    spi_tx_unpack #(.W(W)) i_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .word  (tx_data),
        .shift (tx_shift),
        .msb   (mosi),
        .last  (tx_last),
        .empty (tx_empty)
    );

    spi_rx_pack #(.W(W)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (rx_sample),
        .bit_in    (miso),
        .flush     (rx_flush),
        .out_ready (rx_ready),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .room      (rx_room),
        .out_free  (rx_free),
        .partial   (rx_partial)
    );

    always_comb begin
        d         = q;
        tx_ready  = 1'b0;
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        rx_sample = 1'b0;
        rx_flush  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    d.left  = tx_data[CNT_W-1:0];
                    d.state = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (q.left == '0) begin
                    d.state = ST_IDLE;
                end else begin
                    tx_ready = 1'b1;
                    if (tx_valid) begin
                        tx_load = 1'b1;
                        d.state = ST_ACT;
                        d.ph    = '0;
                    end
                end
            end
            ST_ACT: begin
                d.ph = q.ph + 2'd1;
                if (q.ph == 2'd2) rx_sample = 1'b1;
                if (q.ph == 2'd3) begin
                    tx_shift = 1'b1;
                    d.left   = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) begin
                        d.state = rx_partial ? ST_FLUSH : ST_IDLE;
                    end else if (rx_room && (!tx_last || tx_valid)) begin
                        tx_ready = tx_last;
                        tx_load  = tx_last;
                    end else begin
                        d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (rx_room && (!tx_empty || tx_valid)) begin
                    tx_ready = tx_empty;
                    tx_load  = tx_empty;
                    d.state  = ST_ACT;
                    d.ph     = '0;
                end
            end
            ST_FLUSH: begin
                if (rx_free) begin
                    rx_flush = 1'b1;
                    d.state  = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.ph    <= '0;
            q.left  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cs_n = !(q.state == ST_ACT || q.state == ST_WAIT || q.state == ST_FLUSH);
    assign sclk = (q.state == ST_ACT) && (q.ph[1] ^ cpha);
    assign busy = (q.state != ST_IDLE);

    // R2: the serial clock is idle whenever chip select is inactive
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3: chip select has been high for two cycles before it falls
    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(cs_n) && $past(cs_n, 2)));

    // R4: mosi holds for the rest of a bit once launched
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ACT && q.ph != 2'd0) |-> $stable(mosi));

    // R10: busy covers every cycle with chip select active
    p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // input rule: phase is static during a transfer
    p_phase_static: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cpha));

endmodule

// File: tb/test_spi_stream_master.sv
module test_spi_stream_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpha = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        rx_ready = 1'b1;
    logic        sclk, mosi, cs_n, busy;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit hung    = 1'b0;

    always #2.5ns clk = ~clk;

    spi_stream_master i_spi_stream_master (
        .clk(clk), .rst_n(rst_n), .cpha(cpha),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int n, input int w);
        return (32'h9E37_79B9 * 32'(w + 1)) ^ (32'h0101_0101 * 32'(n)) ^ 32'h5A3C_C3A5;
    endfunction

    task automatic run(input int n, input bit ph, input bit strict, input bit txgap,
                       input bit rxbp, input bit zero_first);
        logic [31:0] txq [0:7];
        logic [31:0] rxw [0:7];
        int  qlen, idx, rx_n, words, qi, k, lowcyc, falls, rises, tmis, bmis, hmis, guard;
        bit  tfire, rfire, prev_low, prev_sclk, prev_mosi, done, prev_hold;
        logic [31:0] prev_data;
        logic [31:0] expw;
        int  r;
        string preq;
        cpha = ph;
        qi = 0;
        if (zero_first) begin txq[0] = 32'd0; qi = 1; end
        txq[qi] = 32'(n);
        words = (n + 31) / 32;
        for (int w = 0; w < words; w++) txq[qi + 1 + w] = pat(n, w);
        qlen = qi + 1 + words;
        idx = 0; rx_n = 0; k = 0; lowcyc = 0; falls = 0; rises = 0; tmis = 0; bmis = 0; hmis = 0;
        tfire = 0; rfire = 0; prev_low = 0; prev_sclk = 0; prev_mosi = 0; done = 0; guard = 0;
        prev_hold = 0; prev_data = '0;
        while (!done && !hung) begin
            @(negedge clk);
            if (tfire) idx++;
            if (rfire) begin
                if (rx_n < 8) rxw[rx_n] = rx_data;
                rx_n++;
            end
            cyc++; guard++;
            tx_valid = (idx < qlen) && !(txgap && (cyc % 5) < 3);
            tx_data  = (idx < 8) ? txq[idx] : 32'h0;
            rx_ready = !(rxbp && (cyc % 7) < 5);
            #1ns;
            if (prev_hold && !(rx_valid && rx_data == prev_data)) hmis++;
            if (!cs_n) begin
                k = prev_low ? k + 1 : 0;
                if (!prev_low) falls++;
                lowcyc++;
                if (!busy) bmis++;
                if (strict) begin
                    if (k < 4 * n) begin
                        if (sclk != ((((k % 4) >= 2) ? 1'b1 : 1'b0) ^ ph)) tmis++;
                        if (k % 4 != 0 && mosi != prev_mosi) tmis++;
                    end else if (sclk) tmis++;
                    miso = ((k % 4) == 2) ? mosi : ~mosi;
                end else begin
                    miso = mosi;
                end
            end else begin
                miso = 1'b0;
            end
            if (sclk && !prev_sclk) rises++;
            prev_low  = !cs_n;
            prev_sclk = sclk;
            prev_mosi = mosi;
            prev_hold = rx_valid && !rx_ready;
            prev_data = rx_data;
            tfire = tx_valid && tx_ready;
            rfire = rx_valid && rx_ready;
            done  = (idx == qlen) && !busy && !tfire && !rx_valid;
            if (guard > 6000) begin
                hung = 1'b1;
                check(1'b0, "R1 watchdog", guard, 6000);
            end
        end
        tx_valid = 1'b0;
        preq = ph ? "R5" : "R4";
        check(rx_n == words, "R7 receive word count", rx_n, words);
        for (int w = 0; w < words && w < 8 && w < rx_n; w++) begin
            expw = pat(n, w);
            r = n - 32 * w;
            if (r < 32) expw = expw & (32'hFFFF_FFFF << (32 - r));
            check(rxw[w] == expw, "R6/R7 received word", rxw[w], expw);
        end
        check(falls == 1, "R3 single chip-select window (R1 count word)", falls, 1);
        check(rises == n, "R2 sclk rising edges", rises, n);
        check(bmis == 0, "R10 busy during chip select", bmis, 0);
        check(busy == 1'b0 && cs_n == 1'b1, "R10 busy and cs_n after transfer", {busy, cs_n}, 2'b01);
        if (strict) begin
            check(lowcyc == 4 * n + ((n % 32) != 0 ? 1 : 0), "R2 chip-select low cycles",
                  lowcyc, 4 * n + ((n % 32) != 0 ? 1 : 0));
            check(tmis == 0, {preq, " sclk/mosi edge timing"}, tmis, 0);
        end
        if (txgap) check(rx_n == words, "R8 data intact across transmit stalls", rx_n, words);
        if (rxbp) begin
            check(hmis == 0, "R11 rx word held until accepted", hmis, 0);
            check(rx_n == words, "R9 no receive word dropped", rx_n, words);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        check(cs_n == 1'b1, "R3 cs_n high after reset", cs_n, 1);
        check(sclk == 1'b0, "R2 sclk low after reset", sclk, 0);
        check(busy == 1'b0, "R10 busy low after reset", busy, 0);
        check(rx_valid == 1'b0, "R11 rx_valid low after reset", rx_valid, 0);
        for (int p = 0; p < 2; p++) begin
            for (int n = 1; n <= 70 && !hung; n++) run(n, p[0], 1'b1, 1'b0, 1'b0, 1'b0);
            if (!hung) run(100, p[0], 1'b1, 1'b0, 1'b0, 1'b0);
            if (!hung) run(100, p[0], 1'b0, 1'b1, 1'b0, 1'b0);
            if (!hung) run(100, p[0], 1'b0, 1'b0, 1'b1, 1'b0);
            if (!hung) run(65, p[0], 1'b0, 1'b1, 1'b1, 1'b0);
            if (!hung) run(5, p[0], 1'b1, 1'b0, 1'b0, 1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule